// File: doc/BRIEF.md
# Core Idle State Sequencer

This block moves one processor core between the running condition and a ladder of idle depths. Software enters idle in one of two ways. A halt request always lands in the shallowest depth. A monitor-wait request carries an 8-bit hint, and that hint names both the target depth and a substate within it. Once a request is accepted, the sequencer works through an ordered list of power-saving steps. Each step is a level handshake with a partner: the cache flush engine, the state-save memory, the core clock gate or the core rail switch. The partner confirms a step by making its acknowledge equal to the request. Leaving idle walks the same steps back in reverse order.

The engaged steps are kept as a bit vector in a fixed order: flush, save, clock gate, rail off. The next entry step is the lowest bit that the target depth still needs. The next exit step is the highest bit currently engaged. Because of this, a wake event that arrives part way through entry unwinds only the steps that were raised, including one whose acknowledge is still outstanding. Every wait for an acknowledge is bounded by a timeout limit supplied on an input. When the limit expires, a flag is raised and the sequence carries on.

Top module: `core_idle_seq`

## Requirements
- R1: After reset all four step requests are low, `idle_depth` and `idle_sub` are 0 and `step_timeout` is low.
- R2: In a monitor-wait hint, bits [7:4] give the depth code and bits [3:0] give the substate. The depth codes are 0 = C1, 1 = C3, 2 = C6, 3 = C7 and 4 = C8. Once entry completes, `idle_depth` reports the depth code plus one (1 = C1 up to 5 = C8) and `idle_sub` reports the substate.
- R3: A depth code above 4 is demoted to C8 with substate 0. A substate above the maximum for its depth is demoted to that maximum. The maximum is C1_SUBS-1 for C1 (default 1, where substate 1 is the enhanced C1) and 0 for every other depth.
- R4: A halt request enters C1 with substate HALT_SUB (default 1). A halt request wins over a monitor-wait request in the same cycle.
- R5: C1 uses only the clock gate step. C3 raises the flush request and then the clock gate request. Exit releases them in the reverse order.
- R6: C6, C7 and C8 all use the same sequence: flush, save, clock gate, rail off. Exit releases rail off, then clock gate, then save (restore), then flush.
- R7: At most one request line changes in any cycle. The next entry step is not raised until the previous step has been acknowledged or has timed out.
- R8: `wake_irq` wakes the core from any idle entry. `mon_write` wakes the core only if it entered through a monitor-wait request. After a halt entry it has no effect.
- R9: A wake during entry aborts the entry. Only the requests already raised are released, in reverse order. `idle_depth` never becomes nonzero, and steps that were never raised stay low.
- R10: If a step's acknowledge does not match its request within `tmo_limit`+1 waiting cycles, `step_timeout` goes high and the sequence proceeds as if the step had been acknowledged. The flag clears when the next request is accepted.
- R11: `idle_depth` is nonzero only once every step for the target depth has been engaged. While it is nonzero the clock gate request is high. A `wake_irq` seen in that state makes `idle_depth` return to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt entry request, one-cycle pulse |
| mwait_req | input | 1 | Monitor-wait entry request, one-cycle pulse |
| mwait_hint | input | 8 | Target depth [7:4] and substate [3:0] |
| wake_irq | input | 1 | Interrupt wake |
| mon_write | input | 1 | Write seen on the monitored address range |
| tmo_limit | input | TW | Acknowledge timeout limit in cycles |
| flush_req | output | 1 | Flush private caches to the shared cache |
| flush_ack | input | 1 | Flush engine acknowledge, follows flush_req |
| save_req | output | 1 | High: save state; falling: restore state |
| save_ack | input | 1 | Save memory acknowledge |
| gate_req | output | 1 | Stop the core clocks |
| gate_ack | input | 1 | Clock gate acknowledge |
| rail_off_req | output | 1 | Take the core rail to zero |
| rail_off_ack | input | 1 | Power switch acknowledge |
| idle_depth | output | 4 | Idle depth reached, 0 when not fully idle |
| idle_sub | output | 4 | Substate reached |
| step_timeout | output | 1 | An acknowledge timed out during the last sequence |

## Verification
The hardest case to bring about from the ports is an aborted entry. The wake has to land while a deep entry has completed some steps but is still waiting on another. The bench makes the save memory partner respond slowly. It watches the save request rise after the flush has been acknowledged, and raises the interrupt in that gap. It then checks that the recorded sequence of request edges is exactly flush up, save up, save down, flush down, and that no idle depth was ever reported. The timeout case is reached by a clock gate partner that never acknowledges.

// File: rtl/cis_pkg.sv
package cis_pkg;
  localparam int NSTEP  = 4;
  localparam int DEPTHS = 5;

  typedef logic [NSTEP-1:0] step_vec_t;

  typedef enum logic [2:0] {
    S_RUN, S_ENTER, S_EWAIT, S_IDLE, S_XPICK, S_XWAIT
  } seq_st_t;

  // step order: bit0 flush, bit1 save, bit2 clock gate, bit3 rail off
  function automatic step_vec_t depth_mask(input logic [2:0] code);
    case (code)
      3'd0:    depth_mask = 4'b0100;
      3'd1:    depth_mask = 4'b0101;
      default: depth_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [1:0] lsb_idx(input step_vec_t v);
    lsb_idx = '0;
    for (int i = NSTEP - 1; i >= 0; i--)
      if (v[i]) lsb_idx = 2'(i);
  endfunction

  function automatic logic [1:0] msb_idx(input step_vec_t v);
    msb_idx = '0;
    for (int i = 0; i < NSTEP; i++)
      if (v[i]) msb_idx = 2'(i);
  endfunction
endpackage

// File: rtl/cis_decode.sv
module cis_decode
  import cis_pkg::*;
#(
  parameter int C1_SUBS  = 2,
  parameter int HALT_SUB = 1
) (
  input  logic       halt,
  input  logic [7:0] hint,
  output logic [2:0] depth,
  output logic [3:0] sub,
  output step_vec_t  mask
);
  localparam logic [3:0] C1_MAX   = 4'(C1_SUBS - 1);
  localparam logic [3:0] DEEPEST  = 4'(DEPTHS - 1);

  logic [3:0] dreq, sreq, smax;

  always_comb begin
    dreq = hint[7:4];
    sreq = hint[3:0];
    smax = (dreq == 4'd0) ? C1_MAX : 4'd0;
    if (halt) begin
      depth = 3'd0;
      sub   = 4'(HALT_SUB);
    end else if (dreq > DEEPEST) begin
      depth = DEEPEST[2:0];
      sub   = 4'd0;
    end else begin
      depth = dreq[2:0];
      sub   = (sreq > smax) ? smax : sreq;
    end
    mask = depth_mask(depth);
  end
endmodule

// File: rtl/cis_timer.sv
module cis_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import cis_pkg::*;
#(
  parameter int TW       = 8,
  parameter int C1_SUBS  = 2,
  parameter int HALT_SUB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_req,
  input  logic          mwait_req,
  input  logic [7:0]    mwait_hint,
  input  logic          wake_irq,
  input  logic          mon_write,
  input  logic [TW-1:0] tmo_limit,
  output logic          flush_req,
  input  logic          flush_ack,
  output logic          save_req,
  input  logic          save_ack,
  output logic          gate_req,
  input  logic          gate_ack,
  output logic          rail_off_req,
  input  logic          rail_off_ack,
  output logic [3:0]    idle_depth,
  output logic [3:0]    idle_sub,
  output logic          step_timeout
);
  seq_st_t    st;
  step_vec_t  req, ack, mask_q, pending, d_mask;
  logic [1:0] cur;
  logic [2:0] dq, d_depth;
  logic [3:0] sq, d_sub;
  logic       by_mw, err, wake, expired, waiting;

  cis_decode #(.C1_SUBS(C1_SUBS), .HALT_SUB(HALT_SUB)) u_dec (
    .halt(halt_req), .hint(mwait_hint),
    .depth(d_depth), .sub(d_sub), .mask(d_mask)
  );

  assign waiting = (st == S_EWAIT) || (st == S_XWAIT);

  cis_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(waiting),
    .limit(tmo_limit), .expired(expired)
  );

  assign ack     = {rail_off_ack, gate_ack, save_ack, flush_ack};
  assign wake    = wake_irq | (mon_write & by_mw);
  assign pending = mask_q & ~req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      req    <= '0;
      cur    <= '0;
      dq     <= '0;
      sq     <= '0;
      mask_q <= '0;
      by_mw  <= 1'b0;
      err    <= 1'b0;
    end else begin
      case (st)
        S_RUN: if ((halt_req || mwait_req) && !wake_irq) begin
          dq     <= d_depth;
          sq     <= d_sub;
          mask_q <= d_mask;
          by_mw  <= !halt_req;
          err    <= 1'b0;
          st     <= S_ENTER;
        end
        S_ENTER: begin
          if (wake)                 st <= S_XPICK;
          else if (pending == '0)   st <= S_IDLE;
          else begin
            cur                   <= lsb_idx(pending);
            req[lsb_idx(pending)] <= 1'b1;
            st                    <= S_EWAIT;
          end
        end
        S_EWAIT: begin
          if (wake)          st <= S_XPICK;
          else if (ack[cur]) st <= S_ENTER;
          else if (expired) begin
            err <= 1'b1;
            st  <= S_ENTER;
          end
        end
        S_IDLE: if (wake) st <= S_XPICK;
        S_XPICK: begin
          if (req == '0) st <= S_RUN;
          else begin
            cur               <= msb_idx(req);
            req[msb_idx(req)] <= 1'b0;
            st                <= S_XWAIT;
          end
        end
        S_XWAIT: begin
          if (!ack[cur]) st <= S_XPICK;
          else if (expired) begin
            err <= 1'b1;
            st  <= S_XPICK;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign flush_req    = req[0];
  assign save_req     = req[1];
  assign gate_req     = req[2];
  assign rail_off_req = req[3];
  assign idle_depth   = (st == S_IDLE) ? (4'(dq) + 4'd1) : 4'd0;
  assign idle_sub     = (st == S_IDLE) ? sq : 4'd0;
  assign step_timeout = err;
endmodule

// File: rtl/core_idle_seq_chk.sv
module core_idle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_irq,
  input logic       flush_req,
  input logic       save_req,
  input logic       gate_req,
  input logic       rail_off_req,
  input logic [3:0] idle_depth
);
  logic [3:0] reqv;
  assign reqv = {rail_off_req, gate_req, save_req, flush_req};

  a_r6_rail_after_save_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rail_off_req |-> (save_req && gate_req));

  a_r6_save_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |-> flush_req);

  a_r7_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reqv ^ $past(reqv)) <= 1);

  a_r11_idle_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_depth != 4'd0) |-> gate_req);

  a_r11_irq_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_depth != 4'd0 && wake_irq) |=> (idle_depth == 4'd0));

  a_r2_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
    idle_depth <= 4'd5);

  a_r5_c1_gate_only: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_depth == 4'd1) |-> (!flush_req && !save_req && !rail_off_req));

  a_r5_c3_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_depth == 4'd2) |-> (flush_req && gate_req && !save_req && !rail_off_req));
endmodule

bind core_idle_seq core_idle_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake_irq(wake_irq),
  .flush_req(flush_req), .save_req(save_req), .gate_req(gate_req),
  .rail_off_req(rail_off_req), .idle_depth(idle_depth)
);

// File: tb/core_idle_seq_test.sv
`timescale 1ns/1ps
module core_idle_seq_test;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, mwait_req = 1'b0, wake_irq = 1'b0, mon_write = 1'b0;
  logic [7:0] mwait_hint = '0;
  logic [TW-1:0] tmo_limit = 8'd60;
  logic flush_req, save_req, gate_req, rail_off_req;
  logic [3:0] ackv = '0;
  logic [3:0] idle_depth, idle_sub;
  logic step_timeout;

  int errors = 0, checks = 0;
  int dly [4] = '{2, 2, 2, 2};
  logic [3:0] stuck = '0;
  int cnt [4] = '{0, 0, 0, 0};
  longint sig = 0;
  logic [3:0] prevq = '0;
  logic depth_seen = 1'b0;

  always #10 clk = ~clk;

  core_idle_seq #(.TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .mwait_req(mwait_req),
    .mwait_hint(mwait_hint), .wake_irq(wake_irq), .mon_write(mon_write),
    .tmo_limit(tmo_limit),
    .flush_req(flush_req), .flush_ack(ackv[0]),
    .save_req(save_req), .save_ack(ackv[1]),
    .gate_req(gate_req), .gate_ack(ackv[2]),
    .rail_off_req(rail_off_req), .rail_off_ack(ackv[3]),
    .idle_depth(idle_depth), .idle_sub(idle_sub), .step_timeout(step_timeout)
  );

  wire [3:0] rq = {rail_off_req, gate_req, save_req, flush_req};

  // handshake partners: acknowledge follows request after a delay
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (ackv[i] != rq[i]) begin
        if (cnt[i] >= dly[i] && !(stuck[i] && rq[i])) begin
          ackv[i] <= rq[i];
          cnt[i]  <= 0;
        end else cnt[i] <= cnt[i] + 1;
      end else cnt[i] <= 0;
    end
  end

  // edge log of request lines
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++)
      if (rq[i] != prevq[i]) sig = (sig << 4) | longint'(i * 2 + int'(rq[i]) + 1);
    prevq = rq;
    if (idle_depth != 0) depth_seen = 1'b1;
  end

  function automatic longint p(longint s, int b, int v);
    return (s << 4) | longint'(b * 2 + v + 1);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic request(logic h, logic [7:0] hint);
    @(negedge clk);
    halt_req = h; mwait_req = !h; mwait_hint = hint;
    @(negedge clk);
    halt_req = 0; mwait_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      if (idle_depth != 0) break;
      @(negedge clk);
    end
  endtask

  task automatic wake(logic irq);
    @(negedge clk);
    wake_irq = irq; mon_write = !irq;
    @(negedge clk);
    wake_irq = 0; mon_write = 0;
  endtask

  task automatic wait_run();
    for (int i = 0; i < 300; i++) begin
      if (rq == 0 && ackv == 0 && idle_depth == 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_log();
    sig = 0; depth_seen = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 requests low", longint'(rq), 0);
    chk("R1 depth zero", longint'(idle_depth), 0);
    chk("R1 sub zero", longint'(idle_sub), 0);
    chk("R1 timeout low", longint'(step_timeout), 0);
  endtask

  task automatic t_halt();
    clear_log();
    request(1'b1, 8'h42);
    wait_idle();
    chk("R4 halt depth C1", longint'(idle_depth), 1);
    chk("R4 halt sub", longint'(idle_sub), 1);
    chk("R5 C1 gate only", longint'(rq), 4'b0100);
    wake(1'b0);
    repeat (8) @(negedge clk);
    chk("R8 monitor write ignored after halt", longint'(idle_depth), 1);
    @(negedge clk); wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    chk("R11 irq exit next cycle", longint'(idle_depth), 0);
    wait_run();
    chk("R5 C1 edge order", sig, p(p(0, 2, 1), 2, 0));
  endtask

  task automatic t_c3_mon();
    clear_log();
    request(1'b0, 8'h10);
    wait_idle();
    chk("R2 C3 depth", longint'(idle_depth), 2);
    wake(1'b0);
    wait_run();
    chk("R8 monitor write wakes", longint'(idle_depth), 0);
    chk("R5 C3 edge order", sig, p(p(p(p(0, 0, 1), 2, 1), 2, 0), 0, 0));
  endtask

  task automatic t_c6_order();
    clear_log();
    request(1'b0, 8'h20);
    wait_idle();
    chk("R2 C6 depth", longint'(idle_depth), 3);
    wake(1'b1);
    wait_run();
    chk("R6 C6 edge order", sig,
        p(p(p(p(p(p(p(p(0, 0, 1), 1, 1), 2, 1), 3, 1), 3, 0), 2, 0), 1, 0), 0, 0));
  endtask

  task automatic one_hint(string tag, logic [7:0] hint, int ed, int es);
    request(1'b0, hint);
    wait_idle();
    chk({tag, " depth"}, longint'(idle_depth), ed);
    chk({tag, " sub"}, longint'(idle_sub), es);
    wake(1'b1);
    wait_run();
  endtask

  task automatic t_decode();
    one_hint("R2 C1 sub0", 8'h00, 1, 0);
    one_hint("R2 C1E", 8'h01, 1, 1);
    one_hint("R2 C7", 8'h30, 4, 0);
    one_hint("R2 C8", 8'h40, 5, 0);
    one_hint("R3 depth demote", 8'h93, 5, 0);
    one_hint("R3 C1 sub demote", 8'h05, 1, 1);
    one_hint("R3 C3 sub demote", 8'h13, 2, 0);
  endtask

  task automatic t_abort();
    clear_log();
    dly[1] = 25;
    request(1'b0, 8'h20);
    for (int i = 0; i < 100; i++) begin
      if (save_req) break;
      @(negedge clk);
    end
    wake_irq = 1;
    @(negedge clk); wake_irq = 0;
    wait_run();
    dly[1] = 2;
    chk("R9 abort unwinds raised steps", sig, p(p(p(p(0, 0, 1), 1, 1), 1, 0), 0, 0));
    chk("R9 no depth reported", longint'(depth_seen), 0);
  endtask

  task automatic t_timeout();
    stuck[2] = 1'b1; tmo_limit = 8'd4;
    request(1'b1, 8'h00);
    wait_idle();
    chk("R10 timeout flag", longint'(step_timeout), 1);
    chk("R10 sequence proceeds", longint'(idle_depth), 1);
    wake(1'b1);
    wait_run();
    stuck[2] = 1'b0; tmo_limit = 8'd60;
    request(1'b1, 8'h00);
    wait_idle();
    chk("R10 flag cleared by new request", longint'(step_timeout), 0);
    wake(1'b1);
    wait_run();
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_c3_mon();
    t_c6_order();
    t_decode();
    t_abort();
    t_timeout();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule